// File: doc/BRIEF.md
# Self-Test Byte Pattern Sequencer

This block sits on the 8-bit parallel side of a transmit channel, ahead of the 8B/10B encoder. In normal operation it registers the user's byte, control flag, valid strobe and transmit mode select, and passes them on one word clock later. When the self-test enable is high, it takes over the channel and ignores the user inputs.

In self-test it first sends a run of K28.5 comma characters so that the far end can re-center its elastic buffers. It then repeats a fixed frame with no gap between frames. Each frame is 256 data words counting up from 0x00 to 0xFF, followed by three K28.5 idles. During self-test the mode select output is held at its default value and the valid strobe stays high.

When the enable drops, the block goes back to pass-through on the next word and clears its sequence. The next entry into self-test therefore starts again with the sync run.

Top module: `bist_pattern_gen`

## Requirements
- R1: While rst_ni is low, byte_o, k_o, valid_o and mode_o are all zero.
- R2: When test_en_i is low at a rising clock edge, byte_o, k_o, valid_o and mode_o take the values of usr_byte_i, usr_k_i, usr_valid_i and usr_mode_i sampled at that edge.
- R3: For the first SYNC_LEN (default 8) edges after test_en_i is sampled high following a low, the output is byte 0xBC with k_o = 1.
- R4: After the sync run comes a data run of 256 words with k_o = 0. The bytes are 0x00, 0x01, ... 0xFF, each one above the previous.
- R5: Each data run is followed by exactly three words of 0xBC with k_o = 1. The next data run then starts at 0x00 on the following word, with no gap.
- R6: While test_en_i is sampled high, valid_o is 1 and mode_o is 3'b000. The values on usr_byte_i, usr_k_i, usr_valid_i and usr_mode_i have no effect on the output.
- R7: When test_en_i is sampled low, the output returns to the user data on that edge. A later entry into self-test starts again with the full sync run, not where the previous run stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_en_i | input | 1 | Self-test enable |
| usr_byte_i | input | 8 | User data byte |
| usr_k_i | input | 1 | User control-character flag |
| usr_valid_i | input | 1 | User word valid |
| usr_mode_i | input | 3 | User transmit mode select |
| byte_o | output | 8 | Byte to the encoder |
| k_o | output | 1 | Control-character flag to the encoder |
| valid_o | output | 1 | Word valid to the encoder |
| mode_o | output | 3 | Transmit mode select, forced to 000 in self-test |

## Verification
Pass-through is driven with random user bytes, flags and mode values. This separates a correct one-word register stage from a stuck or mis-routed field. A long self-test window covers the sync prefix and more than two full frames, with random user inputs still applied. That window catches an off-by-one in the sync, data or idle lengths, a missing wrap to 0x00, and any leak of user data into the pattern. A short self-test burst is cut off in the middle of the data run and followed at once by a new entry. That run separates a sequencer that properly restarts with the sync run from one that resumes where it stopped.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam logic [7:0] K28_5 = 8'hBC;
  typedef enum logic [1:0] {PH_OFF, PH_SYNC, PH_DATA, PH_IDLE} phase_e;
endpackage

// File: rtl/bist_seq.sv
module bist_seq
  import bist_pkg::*;
#(
  parameter int SYNC_LEN = 8,
  parameter int DATA_LEN = 256,
  parameter int IDLE_LEN = 3,
  localparam int MAX_LEN = (SYNC_LEN > DATA_LEN) ? ((SYNC_LEN > IDLE_LEN) ? SYNC_LEN : IDLE_LEN)
                                                 : ((DATA_LEN > IDLE_LEN) ? DATA_LEN : IDLE_LEN),
  localparam int CW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output phase_e        phase_d_o,
  output logic [CW-1:0] cnt_d_o
);
  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // state names the word currently on the output
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q + CW'(1);
    if (!en_i) begin
      phase_d = PH_OFF;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_OFF: begin
          phase_d = PH_SYNC;
          cnt_d   = '0;
        end
        PH_SYNC: if (cnt_q == CW'(SYNC_LEN - 1)) begin
          phase_d = PH_DATA;
          cnt_d   = '0;
        end
        PH_DATA: if (cnt_q == CW'(DATA_LEN - 1)) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
        PH_IDLE: if (cnt_q == CW'(IDLE_LEN - 1)) begin
          phase_d = PH_DATA;
          cnt_d   = '0;
        end
        default: begin
          phase_d = PH_OFF;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_d_o = phase_d;
  assign cnt_d_o   = cnt_d;
endmodule

// File: rtl/bist_out_reg.sv
module bist_out_reg
  import bist_pkg::*;
#(
  parameter int BW = 8,
  parameter int MW = 3,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        phase_d_i,
  input  logic [CW-1:0] cnt_d_i,
  input  logic [BW-1:0] usr_byte_i,
  input  logic          usr_k_i,
  input  logic          usr_valid_i,
  input  logic [MW-1:0] usr_mode_i,
  output logic [BW-1:0] byte_o,
  output logic          k_o,
  output logic          valid_o,
  output logic [MW-1:0] mode_o
);
  logic [BW-1:0] byte_d;
  logic          k_d, valid_d;
  logic [MW-1:0] mode_d;
  logic [BW-1:0] cnt_byte;

  generate
    if (CW >= BW) begin : g_trunc
      assign cnt_byte = cnt_d_i[BW-1:0];
    end else begin : g_pad
      assign cnt_byte = {{(BW-CW){1'b0}}, cnt_d_i};
    end
  endgenerate

  always_comb begin
    byte_d  = BW'(K28_5);
    k_d     = 1'b1;
    valid_d = 1'b1;
    mode_d  = '0;
    unique case (phase_d_i)
      PH_OFF: begin
        byte_d  = usr_byte_i;
        k_d     = usr_k_i;
        valid_d = usr_valid_i;
        mode_d  = usr_mode_i;
      end
      PH_DATA: begin
        byte_d = cnt_byte;
        k_d    = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o  <= '0;
      k_o     <= 1'b0;
      valid_o <= 1'b0;
      mode_o  <= '0;
    end else begin
      byte_o  <= byte_d;
      k_o     <= k_d;
      valid_o <= valid_d;
      mode_o  <= mode_d;
    end
  end
endmodule

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen
  import bist_pkg::*;
#(
  parameter int SYNC_LEN = 8,
  parameter int DATA_LEN = 256,
  parameter int IDLE_LEN = 3,
  parameter int BW = 8,
  parameter int MW = 3,
  localparam int MAX_LEN = (SYNC_LEN > DATA_LEN) ? ((SYNC_LEN > IDLE_LEN) ? SYNC_LEN : IDLE_LEN)
                                                 : ((DATA_LEN > IDLE_LEN) ? DATA_LEN : IDLE_LEN),
  localparam int CW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          test_en_i,
  input  logic [BW-1:0] usr_byte_i,
  input  logic          usr_k_i,
  input  logic          usr_valid_i,
  input  logic [MW-1:0] usr_mode_i,
  output logic [BW-1:0] byte_o,
  output logic          k_o,
  output logic          valid_o,
  output logic [MW-1:0] mode_o
);
  phase_e        phase_d;
  logic [CW-1:0] cnt_d;

  bist_seq #(.SYNC_LEN(SYNC_LEN), .DATA_LEN(DATA_LEN), .IDLE_LEN(IDLE_LEN)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (test_en_i),
    .phase_d_o (phase_d),
    .cnt_d_o   (cnt_d)
  );

  bist_out_reg #(.BW(BW), .MW(MW), .CW(CW)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_d_i   (phase_d),
    .cnt_d_i     (cnt_d),
    .usr_byte_i  (usr_byte_i),
    .usr_k_i     (usr_k_i),
    .usr_valid_i (usr_valid_i),
    .usr_mode_i  (usr_mode_i),
    .byte_o      (byte_o),
    .k_o         (k_o),
    .valid_o     (valid_o),
    .mode_o      (mode_o)
  );
endmodule

// File: rtl/bist_pattern_gen_chk.sv
module bist_pattern_gen_chk #(
  parameter int BW = 8,
  parameter int MW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          test_en_i,
  input logic [BW-1:0] usr_byte_i,
  input logic          usr_k_i,
  input logic          usr_valid_i,
  input logic [MW-1:0] usr_mode_i,
  input logic [BW-1:0] byte_o,
  input logic          k_o,
  input logic          valid_o,
  input logic [MW-1:0] mode_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      p_reset_zero_r1: assert (byte_o == '0 && !k_o && !valid_o && mode_o == '0);
    end
  end

  p_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |=> byte_o == $past(usr_byte_i) && k_o == $past(usr_k_i)
                && valid_o == $past(usr_valid_i) && mode_o == $past(usr_mode_i));

  p_entry_sync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(test_en_i) |=> k_o && byte_o == BW'(8'hBC));

  p_data_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_en_i && $past(test_en_i) && !k_o && byte_o != {BW{1'b1}}
    |=> !k_o && byte_o == ($past(byte_o) + BW'(1)));

  p_idle_after_ff_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_en_i && $past(test_en_i) && !k_o && byte_o == {BW{1'b1}}
    |=> k_o && byte_o == BW'(8'hBC));

  p_test_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_en_i |=> valid_o && mode_o == '0);
endmodule

bind bist_pattern_gen bist_pattern_gen_chk #(.BW(BW), .MW(MW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .test_en_i   (test_en_i),
  .usr_byte_i  (usr_byte_i),
  .usr_k_i     (usr_k_i),
  .usr_valid_i (usr_valid_i),
  .usr_mode_i  (usr_mode_i),
  .byte_o      (byte_o),
  .k_o         (k_o),
  .valid_o     (valid_o),
  .mode_o      (mode_o)
);

// File: tb/bist_pattern_gen_tb.sv
module bist_pattern_gen_tb;
  localparam int SYNC = 8;
  localparam int FRAME = 256 + 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       te = 1'b0;
  logic [7:0] ub = '0;
  logic       uk = 1'b0, uv = 1'b0;
  logic [2:0] um = '0;
  logic [7:0] byte_o;
  logic       k_o, valid_o;
  logic [2:0] mode_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bist_pattern_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .test_en_i(te),
    .usr_byte_i(ub), .usr_k_i(uk), .usr_valid_i(uv), .usr_mode_i(um),
    .byte_o(byte_o), .k_o(k_o), .valid_o(valid_o), .mode_o(mode_o)
  );

  // behavioural reference
  logic [7:0] e_b;
  logic       e_k, e_v;
  logic [2:0] e_m;
  int         idx = 0;
  bit         was_test = 0;
  string      tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_b = 0; e_k = 0; e_v = 0; e_m = 0; idx = 0; was_test = 0; tag = "R1";
    end else if (te) begin
      if (idx < SYNC) begin
        e_b = 8'hBC; e_k = 1; tag = "R3";
      end else begin
        int m;
        m = (idx - SYNC) % FRAME;
        if (m < 256) begin e_b = 8'(m); e_k = 0; tag = "R4"; end
        else begin e_b = 8'hBC; e_k = 1; tag = "R5"; end
      end
      if (idx >= SYNC && idx - SYNC >= FRAME && idx - SYNC < FRAME + SYNC) tag = "R7";
      e_v = 1; e_m = 0; idx++; was_test = 1;
    end else begin
      e_b = ub; e_k = uk; e_v = uv; e_m = um;
      tag = was_test ? "R7" : "R2";
      idx = 0; was_test = 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (byte_o !== e_b || k_o !== e_k) begin
        fails++;
        $display("FAIL %s byte/k actual %02h/%0b expected %02h/%0b", tag, byte_o, k_o, e_b, e_k);
      end
      checks++;
      if (valid_o !== e_v || mode_o !== e_m) begin
        fails++;
        $display("FAIL %s valid/mode actual %0b/%0d expected %0b/%0d (R6 in test)",
                 tag, valid_o, mode_o, e_v, e_m);
      end
    end
  end

  task automatic run(input bit t, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      te = t;
      ub = 8'($urandom); uk = 1'($urandom); uv = 1'($urandom); um = 3'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);      // R1 checked while reset low
    rst_n = 1'b1;
    run(0, 20);                     // R2 pass-through
    run(1, SYNC + 2 * FRAME + 20);  // R3 R4 R5 R6, user inputs random
    run(0, 5);                      // R7 exit
    run(1, SYNC + 100);             // cut in mid data run
    run(0, 1);
    run(1, SYNC + FRAME + 10);      // R7 re-entry restarts sync
    run(0, 10);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule